// File: doc/BRIEF.md
# Parallel-Port Command Strobe Receiver

This block sits on the peripheral end of a bidirectional parallel-port link. It handles the host-to-peripheral command phase. The host puts a command byte on the shared data lines, holds its acknowledge line low to mark the byte as a command, and pulls its strobe low. The block waits a programmable number of system-clock cycles so the cable can settle. It then raises its acknowledge toward the host and holds it until the host lets the strobe go high again.

At the moment the acknowledge rises, the block reads the held byte once and turns it into one-cycle control strobes for the rest of the peripheral: one clears the capture FIFO and one starts a scan. Both can fire from the same byte. While the direction line asks for forward transfer, the block keeps its data-bus driver disabled. All host lines are asynchronous and are brought into the system clock domain through two-flop synchronizers.

The decoded strobes are plain one-cycle pulses. There is no valid/ready handshake, because the receiving logic cannot apply back-pressure: a strobe is never held or repeated.

Top module: `ecp_cmd_rx`

## Requirements
- R1: While reset is asserted and just after it, `periph_ack_o`, `data_oe_o`, `fifo_clr_o` and `scan_go_o` are all low.
- R2: `data_oe_o` is high exactly when the synchronized `rev_req_n_i` is low. It follows a change of `rev_req_n_i` on the third rising clock edge after the change. `data_oe_o` and `periph_ack_o` are never high together.
- R3: A falling edge of `host_clk_i` while `rev_req_n_i` is high makes `periph_ack_o` rise on exactly the (SETTLE_CYC+3)-th rising clock edge after the change: two synchronizer edges, one edge-detect edge and SETTLE_CYC counting edges.
- R4: Once `periph_ack_o` is high, it stays high until `host_clk_i` returns high. It falls on the third rising edge after that change.
- R5: If `host_clk_i` returns high before the settle count ends, `periph_ack_o` never rises and no strobe is produced for that cycle.
- R6: Bit 0 of the data byte selects the FIFO clear. When it is 1, `fifo_clr_o` is high for exactly one clock, in the first cycle in which `periph_ack_o` is high.
- R7: Bit 1 of the data byte selects the scan start. When it is 1, `scan_go_o` pulses in the same way. With both bits set, both strobes pulse in the same cycle.
- R8: If the synchronized `host_ack_i` is high when the acknowledge rises (a data cycle, not a command cycle), neither strobe pulses, although `periph_ack_o` still completes the handshake.
- R9: Data bits 7..2 have no effect. Data changes made while `periph_ack_o` is already high produce no further strobes: there is at most one strobe set per command cycle.
- R10: While `rev_req_n_i` is low, falling edges of `host_clk_i` are ignored. If `rev_req_n_i` falls during a command cycle, the cycle is abandoned and `periph_ack_o` falls on the third rising edge after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rev_req_n_i | input | 1 | Host direction request, high = forward (async) |
| host_clk_i | input | 1 | Host strobe, falling edge opens a cycle (async) |
| host_ack_i | input | 1 | Host acknowledge, low marks a command byte (async) |
| data_i | input | 8 | Shared data lines as seen by the receiver (async) |
| periph_ack_o | output | 1 | Peripheral acknowledge toward the host |
| data_oe_o | output | 1 | Enable for the peripheral's data-bus driver |
| fifo_clr_o | output | 1 | One-cycle FIFO clear strobe |
| scan_go_o | output | 1 | One-cycle scan start strobe |

## Verification
The cases that are hardest to reach from the ports are those where the host withdraws in the middle of a cycle. In one, the strobe returns high while the settle count is still running. In the other, the direction line turns around while the acknowledge is already high. In both, the block must drop the cycle without leaving an acknowledge or strobe behind. The bench measures the strobe-to-acknowledge latency in clock edges first. It then times these withdrawals relative to that count: halfway through the settle window, and a few cycles after the acknowledge has risen. A scoreboard receives one expected strobe set per command that should fire. Any strobe with no matching entry is therefore caught, whether it comes from an aborted cycle, a data cycle or late data.

// File: rtl/ecp_cmd_pkg.sv
package ecp_cmd_pkg;

  // Handshake phases of one forward command cycle
  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_SETTLE = 2'd1,
    HS_ACK    = 2'd2
  } hs_state_t;

  // Indices of the decoded strobes
  localparam int STB_CLR = 0;
  localparam int STB_GO  = 1;
  localparam int NUM_STB = 2;

endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
  end

  assign q_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/ecp_settle_hs.sv
module ecp_settle_hs
  import ecp_cmd_pkg::*;
#(
  parameter int SETTLE_CYC = 188
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_i,       // synchronized direction, 1 = forward
  input  logic hclk_i,      // synchronized host strobe
  output logic ack_o,       // acknowledge toward host
  output logic ack_rise_o,  // acknowledge rises at the coming edge
  output logic oe_o         // data driver enable
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  hs_state_t  st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic       hclk_prev_q;
  logic       hclk_fall;
  logic       oe_q;

  assign hclk_fall = hclk_prev_q & ~hclk_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_IDLE:   if (hclk_fall && fwd_i) st_d = HS_SETTLE;
      HS_SETTLE: begin
        if (!fwd_i || hclk_i)      st_d = HS_IDLE;
        else if (cnt_q == CNT_LAST) st_d = HS_ACK;
      end
      HS_ACK:    if (!fwd_i || hclk_i) st_d = HS_IDLE;
      default:   st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= HS_IDLE;
      cnt_q       <= '0;
      hclk_prev_q <= 1'b1;
      oe_q        <= 1'b0;
    end else begin
      st_q        <= st_d;
      hclk_prev_q <= hclk_i;
      oe_q        <= ~fwd_i;
      if (st_q == HS_SETTLE && st_d == HS_SETTLE) cnt_q <= cnt_q + 1'b1;
      else                                         cnt_q <= '0;
    end
  end

  assign ack_o      = (st_q == HS_ACK);
  assign ack_rise_o = (st_q == HS_SETTLE) && (st_d == HS_ACK);
  assign oe_o       = oe_q;

  AST_ACK_AFTER_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> ($past(cnt_q) == CNT_LAST)); // R3
  AST_ACK_DROPS_ON_HCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && hclk_i) |=> !ack_o); // R4
  AST_ACK_DROPS_ON_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !fwd_i) |=> !ack_o); // R10
  AST_NO_START_IN_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HS_IDLE && !fwd_i) |=> (st_q == HS_IDLE)); // R10

endmodule

// File: rtl/ecp_cmd_dec.sv
module ecp_cmd_dec #(
  parameter int                        DATA_W  = 8,
  parameter int                        NSTB    = 2,
  parameter logic [NSTB*DATA_W-1:0]    SEL_MSK = 16'h0201
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_rise_i,
  input  logic              host_ack_i,
  input  logic [DATA_W-1:0] cmd_i,
  output logic [NSTB-1:0]   stb_o
);

  logic [NSTB-1:0] hit;
  logic [NSTB-1:0] stb_q;
  logic            fire;

  assign fire = ack_rise_i & ~host_ack_i;

  for (genvar i = 0; i < NSTB; i++) begin : g_stb
    assign hit[i] = |(cmd_i & SEL_MSK[i*DATA_W +: DATA_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q[i] <= 1'b0;
      else        stb_q[i] <= fire & hit[i];
    end

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q[i] |=> !stb_q[i]); // R6 R7
  end

  assign stb_o = stb_q;

  AST_NO_STB_IN_DATA_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb_q) |-> !$past(host_ack_i)); // R8

endmodule

// File: rtl/ecp_cmd_rx.sv
module ecp_cmd_rx
  import ecp_cmd_pkg::*;
#(
  parameter int SETTLE_CYC  = 188,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rev_req_n_i,
  input  logic              host_clk_i,
  input  logic              host_ack_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              periph_ack_o,
  output logic              data_oe_o,
  output logic              fifo_clr_o,
  output logic              scan_go_o
);

  localparam int SYNC_W = DATA_W + 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b1, 1'b0, {DATA_W{1'b0}}};
  localparam logic [NUM_STB*DATA_W-1:0] STB_MASKS =
    {DATA_W'(1) << 1, DATA_W'(1)};

  logic [SYNC_W-1:0]  raw_in, syn;
  logic               s_fwd, s_hclk, s_hack;
  logic [DATA_W-1:0]  s_data;
  logic               ack_rise;
  logic [NUM_STB-1:0] stb;

  assign raw_in = {rev_req_n_i, host_clk_i, host_ack_i, data_i};

  ecp_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_in),
    .q_o  (syn)
  );

  assign {s_fwd, s_hclk, s_hack, s_data} = syn;

  ecp_settle_hs #(
    .SETTLE_CYC(SETTLE_CYC)
  ) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd_i     (s_fwd),
    .hclk_i    (s_hclk),
    .ack_o     (periph_ack_o),
    .ack_rise_o(ack_rise),
    .oe_o      (data_oe_o)
  );

  ecp_cmd_dec #(
    .DATA_W (DATA_W),
    .NSTB   (NUM_STB),
    .SEL_MSK(STB_MASKS)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_rise_i(ack_rise),
    .host_ack_i(s_hack),
    .cmd_i     (s_data),
    .stb_o     (stb)
  );

  assign fifo_clr_o = stb[STB_CLR];
  assign scan_go_o  = stb[STB_GO];

  AST_NO_DRIVE_WHILE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(periph_ack_o && data_oe_o)); // R2
  AST_STB_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr_o || scan_go_o) |-> periph_ack_o); // R6
  AST_STB_ON_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr_o || scan_go_o) |-> $rose(periph_ack_o)); // R9

endmodule

// File: tb/ecp_cmd_rx_test.sv
module ecp_cmd_rx_test;

  localparam int SETTLE = 188;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rev_n = 1'b1;
  logic       hclk = 1'b1;
  logic       hack = 1'b0;
  logic [7:0] data = 8'h00;
  logic       ack, oe, clr, go;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];

  always #4 clk = ~clk;

  ecp_cmd_rx #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .rev_req_n_i(rev_n), .host_clk_i(hclk),
    .host_ack_i(hack), .data_i(data), .periph_ack_o(ack), .data_oe_o(oe),
    .fifo_clr_o(clr), .scan_go_o(go)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops one expected strobe set per observed strobe
  logic prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (clr || go) begin
        if (exp_q.size() == 0) chk(1'b0, "R5/R8/R9 unexpected strobe", {clr, go}, 0);
        else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk({go, clr} == e, "R6/R7 strobe set", {go, clr}, e);
          chk(ack, "R6 strobe with ack", ack, 1);
        end
        chk(!prev_pulse, "R6/R7 one-cycle strobe", prev_pulse, 0);
      end
      prev_pulse = clr | go;
    end
  end

  // Full command cycle; returns after the ack has dropped
  task automatic command(input logic [7:0] d, input logic ha, input bit late_change);
    int k;
    data = d; hack = ha;
    cyc(4);
    if (!ha && d[1:0] != 2'b00) exp_q.push_back({d[1], d[0]});
    hclk = 1'b0;
    k = 0;
    while (!ack && k < SETTLE + 20) begin
      @(posedge clk); k++; @(negedge clk);
    end
    chk(k == SETTLE + 3, "R3 ack latency", k, SETTLE + 3);
    chk(!oe, "R2 driver off during forward ack", oe, 0);
    if (late_change) data = 8'hFF;   // R9 late data
    cyc(6);
    chk(ack, "R4 ack held while strobe low", ack, 1);
    hclk = 1'b1;
    cyc(2);
    chk(ack, "R4 ack still high two edges after release", ack, 1);
    cyc(1);
    chk(!ack, "R4 ack low three edges after release", ack, 0);
    cyc(4);
  endtask

  initial begin
    cyc(3);
    chk(!ack && !oe && !clr && !go, "R1 outputs low in reset", {ack, oe, clr, go}, 0);
    rst_n = 1'b1;
    cyc(3);
    chk(!ack && !oe && !clr && !go, "R1 outputs low after reset", {ack, oe, clr, go}, 0);

    command(8'h01, 1'b0, 1'b0);   // R6
    command(8'h02, 1'b0, 1'b0);   // R7
    command(8'h03, 1'b0, 1'b0);   // R7 both
    command(8'hFC, 1'b0, 1'b0);   // R9 high bits only
    command(8'h03, 1'b1, 1'b0);   // R8 data cycle
    command(8'h01, 1'b0, 1'b1);   // R9 late change
    hack = 1'b0;

    // R5 abort mid-settle
    data = 8'h03; cyc(4);
    hclk = 1'b0; cyc(SETTLE / 2);
    hclk = 1'b1;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < SETTLE + 10; i++) begin cyc(1); if (ack) seen = 1'b1; end
      chk(!seen, "R5 no ack after abort", seen, 0);
    end

    // R2 reverse turnaround timing
    rev_n = 1'b0;
    cyc(2);
    chk(!oe, "R2 oe low two edges after reverse", oe, 0);
    cyc(1);
    chk(oe, "R2 oe high three edges after reverse", oe, 1);

    // R10 strobe ignored in reverse
    hclk = 1'b0;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < SETTLE + 10; i++) begin cyc(1); if (ack) seen = 1'b1; end
      chk(!seen, "R10 no ack in reverse", seen, 0);
    end
    hclk = 1'b1;
    rev_n = 1'b1;
    cyc(3);
    chk(!oe, "R2 oe low back in forward", oe, 0);
    cyc(3);

    // R10 reverse during ack
    data = 8'h02; cyc(4);
    exp_q.push_back(2'b10);
    hclk = 1'b0;
    cyc(SETTLE + 6);
    chk(ack, "R10 ack up before turnaround", ack, 1);
    rev_n = 1'b0;
    cyc(2);
    chk(ack, "R10 ack still high two edges after", ack, 1);
    cyc(1);
    chk(!ack, "R10 ack dropped on reverse", ack, 0);
    hclk = 1'b1; rev_n = 1'b1;
    cyc(10);

    chk(exp_q.size() == 0, "R6/R7 all expected strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule